// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects an on-chip requester to an external asynchronous static RAM of one million 16-bit words. The requester offers one access at a time through a valid/ready handshake. Each access carries a 20-bit word address, a read/write flag, two active-high byte-select bits and 16-bit write data. Reads come back as 16-bit data with a single-cycle valid pulse.

On the memory side the controller drives the address, an active-low chip select, write strobe, output enable and one active-low enable per byte lane. It also drives the shared data bus through three separate ports: an output value, an output-enable and an input value. The pad cell sits outside the block.

Every pin is decoded from registered state. The controller sequences each access over a fixed number of wait cycles, derived from the clock period and the memory's 10 ns access time. It gives the write strobe one cycle of setup and one cycle of hold, and it never drives the bus while the memory may be driving it.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever idle, chip select, write strobe, output enable and both lane enables are high, the bus output-enable is low, and `req_ready` is high. `req_ready` is low for the whole of any memory access.
- R2: A write holds chip select and write strobe low with `mem_addr` equal to the request address. Lane enable `mem_lb_n` (bits 7:0) is low only if `req_be[0]` is 1, and `mem_ub_n` (bits 15:8) is low only if `req_be[1]` is 1. Bytes whose select bit is 0 keep their old contents, and a write produces no `rsp_valid`.
- R3: During a write, address, lane enables and a low chip select are present one cycle before the write strobe falls and are unchanged in the cycle after it rises. `mem_dq_oe` is high exactly while the write strobe is low.
- R4: A read holds chip select and output enable low with the write strobe high and sets the lane enables as in R2. The bus is sampled on the last wait cycle. `rsp_valid` is then high for one cycle, after exactly WAIT clock edges following the edge that accepted the request.
- R5: Byte lanes of `rsp_rdata` whose select bit was 0 return zero, whatever the bus carries on them.
- R6: A request with `req_be` = 0 performs no memory cycle, because chip select stays high. A read of this kind returns zero with `rsp_valid` in the cycle right after the accepting edge. A write of this kind leaves memory unchanged.
- R7: Output enable is never low while `mem_dq_oe` is high, and at least one full cycle with neither asserted separates the end of a write drive from the start of a read.
- R8: WAIT = ceil(10 / CLK_PERIOD_NS) + 1 cycles, which is 4 at the default 4 ns. Each write-strobe pulse and each output-enable pulse lasts exactly WAIT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and accepting |
| req_addr | input | 20 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte selects, bit 0 = bits 7:0 |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| mem_dq_out | output | 16 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Value read from the data bus |

## Verification
The bound checker watches the pin-level rules on every cycle:
- the idle pin state, and `req_ready` holding only while chip select is high;
- the absence of a bus fight, and the dead cycle after a bus drive;
- write-strobe setup and hold stability, and the bus drive tracking the strobe;
- pulse widths, measured with counters.

Stored contents, lane masking of returned data, response latency, and the absence of any memory cycle for zero-select requests depend on what was requested. Only the bench's scenarios can show them, by checking against a memory model and an expected-contents table.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4
  } sc_state_e;
endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int WAIT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = LOAD_VAL;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_mux.sv
module sram_lane_mux #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    active,
  input  logic [LANES-1:0]        be,
  input  logic [LANES*LANE_W-1:0] raw,
  output logic [LANES-1:0]        lane_n,
  output logic [LANES*LANE_W-1:0] masked
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n[g] = !(active && be[g]);
    assign masked[g*LANE_W +: LANE_W] = be[g] ? raw[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      req_write,
  input  logic      be_any,
  input  logic      tmr_done,
  output sc_state_e state_q,
  output logic      req_ready,
  output logic      accept_op,
  output logic      zero_rd,
  output logic      rd_cap,
  output logic      tmr_load
);
  sc_state_e state_d;
  logic      accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign accept_op = accept && be_any;
  assign zero_rd   = accept && !be_any && !req_write;
  assign rd_cap    = (state_q == ST_READ) && tmr_done;
  assign tmr_load  = (accept_op && !req_write) || (state_q == ST_WSETUP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_op) state_d = req_write ? ST_WSETUP : ST_READ;
      ST_READ:   if (tmr_done)  state_d = ST_IDLE;
      ST_WSETUP: state_d = ST_WPULSE;
      ST_WPULSE: if (tmr_done)  state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int LANE_W        = 8,
  parameter int LANES         = 2,
  parameter int ACCESS_NS     = 10,
  parameter int CLK_PERIOD_NS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  input  logic [LANES-1:0]        req_be,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  output logic                    rsp_valid,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic                    mem_lb_n,
  output logic                    mem_ub_n,
  output logic [LANES*LANE_W-1:0] mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_in
);
  localparam int DATA_W   = LANES * LANE_W;
  localparam int WAIT_CYC = (ACCESS_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS + 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  sc_state_e state_q;
  logic      accept_op, zero_rd, rd_cap, tmr_load, tmr_done;

  sram_ctrl_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_s2),
    .req_valid (req_valid),
    .req_write (req_write),
    .be_any    (|req_be),
    .tmr_done  (tmr_done),
    .state_q   (state_q),
    .req_ready (req_ready),
    .accept_op (accept_op),
    .zero_rd   (zero_rd),
    .rd_cap    (rd_cap),
    .tmr_load  (tmr_load)
  );

  sram_wait_timer #(.WAIT_CYC(WAIT_CYC)) i_timer (
    .clk   (clk),
    .rst_n (rst_s2),
    .load  (tmr_load),
    .done  (tmr_done)
  );

  // request holding registers, loaded only on an accepted access
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept_op) begin
      addr_q  <= req_addr;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  logic [LANES-1:0]  lane_n;
  logic [DATA_W-1:0] rd_masked;

  sram_lane_mux #(.LANES(LANES), .LANE_W(LANE_W)) i_lanes (
    .active (state_q != ST_IDLE),
    .be     (be_q),
    .raw    (mem_dq_in),
    .lane_n (lane_n),
    .masked (rd_masked)
  );

  // response registers
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;

  always_comb begin
    rsp_rdata_d = rsp_rdata_q;
    if (rd_cap)       rsp_rdata_d = rd_masked;
    else if (zero_rd) rsp_rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_cap || zero_rd;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign mem_addr   = addr_q;
  assign mem_ce_n   = (state_q == ST_IDLE);
  assign mem_we_n   = (state_q != ST_WPULSE);
  assign mem_oe_n   = (state_q != ST_READ);
  assign mem_dq_oe  = (state_q == ST_WPULSE);
  assign mem_dq_out = wdata_q;
  assign mem_lb_n   = lane_n[0];
  assign mem_ub_n   = lane_n[LANES-1];
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W   = 20,
  parameter int WAIT_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe
);
  logic [7:0] we_run, oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= mem_we_n ? 8'd0 : we_run + 8'd1;
      oe_run <= mem_oe_n ? 8'd0 : oe_run + 8'd1;
    end
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe);
  assert_lanes_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> mem_lb_n && mem_ub_n);
  assert_we_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n) && $past(!mem_ce_n));
  assert_we_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n && $stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n));
  assert_drive_with_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe == !mem_we_n);
  assert_read_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n && !mem_ce_n);
  assert_no_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));
  assert_turn_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |=> mem_oe_n);
  assert_we_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> we_run == 8'(WAIT_CYC));
  assert_oe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> oe_run == 8'(WAIT_CYC));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_lb_n  (mem_lb_n),
  .mem_ub_n  (mem_ub_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;
  localparam int WAIT = 4;   // ceil(10/4)+1

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [19:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #2 clk = ~clk;

  sram_lane_ctrl #(.CLK_PERIOD_NS(4)) i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // memory model: 64 words indexed by low address bits
  logic [15:0] mem [64];
  logic [15:0] expv [64];
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n)
    ? {(mem_ub_n ? 8'hA5 : mem[mem_addr[5:0]][15:8]), (mem_lb_n ? 8'h5A : mem[mem_addr[5:0]][7:0])}
    : 16'hC3C3;

  // monitor, sampled mid-cycle
  int cyc, ce_low_cnt, we_run, last_we_run, oe_run, last_oe_run;
  int last_drive_cyc, min_gap, setup_err, hold_err, fight_cnt, wr_seen;
  logic [19:0] last_wr_addr;
  logic p_ce_n, p_we_n, p_oe_n, p_lb_n, p_ub_n;
  logic [19:0] p_addr;
  initial begin
    cyc = 0; ce_low_cnt = 0; we_run = 0; last_we_run = 0; oe_run = 0; last_oe_run = 0;
    last_drive_cyc = -100; min_gap = 1000; setup_err = 0; hold_err = 0; fight_cnt = 0; wr_seen = 0;
    last_wr_addr = '0;
    p_ce_n = 1'b1; p_we_n = 1'b1; p_oe_n = 1'b1; p_lb_n = 1'b1; p_ub_n = 1'b1; p_addr = '0;
    for (int i = 0; i < 64; i++) begin
      mem[i]  = 16'h1000 + 16'(i);
      expv[i] = 16'h1000 + 16'(i);
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!mem_ce_n) ce_low_cnt <= ce_low_cnt + 1;
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) mem[mem_addr[5:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) mem[mem_addr[5:0]][15:8] <= mem_dq_out[15:8];
      last_wr_addr <= mem_addr;
    end
    if (!mem_we_n) we_run <= we_run + 1;
    else begin
      if (!p_we_n) last_we_run <= we_run;
      we_run <= 0;
    end
    if (!mem_oe_n) oe_run <= oe_run + 1;
    else begin
      if (!p_oe_n) last_oe_run <= oe_run;
      oe_run <= 0;
    end
    if (mem_dq_oe) last_drive_cyc <= cyc;
    if (mem_dq_oe && !mem_oe_n) fight_cnt <= fight_cnt + 1;
    if (p_oe_n && !mem_oe_n && (cyc - last_drive_cyc) < min_gap) min_gap <= cyc - last_drive_cyc;
    if (p_we_n && !mem_we_n) begin
      wr_seen <= wr_seen + 1;
      if (p_ce_n || p_addr != mem_addr || p_lb_n != mem_lb_n || p_ub_n != mem_ub_n)
        setup_err <= setup_err + 1;
    end
    if (!p_we_n && mem_we_n) begin
      if (mem_ce_n || p_addr != mem_addr || p_lb_n != mem_lb_n || p_ub_n != mem_ub_n)
        hold_err <= hold_err + 1;
    end
    p_ce_n <= mem_ce_n; p_we_n <= mem_we_n; p_oe_n <= mem_oe_n;
    p_lb_n <= mem_lb_n; p_ub_n <= mem_ub_n; p_addr <= mem_addr;
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_idle();
    while (!req_ready) step();
  endtask

  // issue one request; returns read data, latency in cycles, ready-low flag, response count
  task automatic do_req(input bit wr, input logic [19:0] a, input logic [1:0] be,
                        input logic [15:0] wd, output logic [15:0] rd, output int lat,
                        output bit busy_seen, output int rsp_cnt);
    wait_idle();
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    step();
    req_valid = 1'b0;
    lat = 1; rsp_cnt = 0; rd = '0;
    busy_seen = !req_ready;
    if (!wr) begin
      while (!rsp_valid && lat < 50) begin step(); lat++; end
      rd = rsp_rdata;
      rsp_cnt = rsp_valid ? 1 : 0;
    end else begin
      while (!req_ready && lat < 50) begin
        if (rsp_valid) rsp_cnt++;
        step(); lat++;
      end
      if (rsp_valid) rsp_cnt++;
    end
  endtask

  task automatic t_reset();
    check(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n, "R1", "idle strobes",
          {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'h1f);
    check(!mem_dq_oe && req_ready && !rsp_valid, "R1", "idle ready/drive",
          {29'd0, req_ready, mem_dq_oe, rsp_valid}, 32'h4);
  endtask

  task automatic t_full_word();
    logic [15:0] rd; int lat, rc; bit busy;
    do_req(1'b1, 20'h00005, 2'b11, 16'hBEEF, rd, lat, busy, rc);
    expv[5] = 16'hBEEF;
    check(busy, "R1", "ready low during write", 32'(busy), 32'd1);
    check(rc == 0, "R2", "no response to write", 32'(rc), 32'd0);
    check(last_we_run == WAIT, "R8", "write strobe width", 32'(last_we_run), 32'(WAIT));
    do_req(1'b0, 20'h00005, 2'b11, 16'h0, rd, lat, busy, rc);
    check(rd == expv[5], "R4", "full word read", 32'(rd), 32'(expv[5]));
    check(lat == WAIT + 1, "R4", "read latency", 32'(lat), 32'(WAIT + 1));
    check(last_oe_run == WAIT, "R8", "output enable width", 32'(last_oe_run), 32'(WAIT));
  endtask

  task automatic t_byte_write();
    logic [15:0] rd; int lat, rc; bit busy;
    do_req(1'b1, 20'h00009, 2'b01, 16'h77AB, rd, lat, busy, rc);
    expv[9][7:0] = 8'hAB;
    do_req(1'b1, 20'h00009, 2'b10, 16'hCD00, rd, lat, busy, rc);
    expv[9][15:8] = 8'hCD;
    do_req(1'b0, 20'h00009, 2'b11, 16'h0, rd, lat, busy, rc);
    check(rd == expv[9], "R2", "byte lane writes merge", 32'(rd), 32'(expv[9]));
    do_req(1'b1, 20'hFFFC7, 2'b11, 16'h4321, rd, lat, busy, rc);
    expv[7] = 16'h4321;
    check(last_wr_addr == 20'hFFFC7, "R2", "write address on pins", 32'(last_wr_addr), 32'hFFFC7);
    do_req(1'b0, 20'hFFFC7, 2'b11, 16'h0, rd, lat, busy, rc);
    check(rd == expv[7], "R2", "high address read back", 32'(rd), 32'(expv[7]));
  endtask

  task automatic t_lane_read();
    logic [15:0] rd; int lat, rc; bit busy;
    do_req(1'b0, 20'h00009, 2'b01, 16'h0, rd, lat, busy, rc);
    check(rd == {8'h00, expv[9][7:0]}, "R5", "low lane only", 32'(rd), 32'({8'h00, expv[9][7:0]}));
    do_req(1'b0, 20'h00009, 2'b10, 16'h0, rd, lat, busy, rc);
    check(rd == {expv[9][15:8], 8'h00}, "R5", "high lane only", 32'(rd), 32'({expv[9][15:8], 8'h00}));
  endtask

  task automatic t_zero_select();
    logic [15:0] rd; int lat, rc, ce0; bit busy;
    ce0 = ce_low_cnt;
    do_req(1'b0, 20'h00009, 2'b00, 16'h0, rd, lat, busy, rc);
    check(rd == 16'h0 && rc == 1, "R6", "zero-select read data", 32'(rd), 32'd0);
    check(lat == 1, "R6", "zero-select read latency", 32'(lat), 32'd1);
    do_req(1'b1, 20'h00009, 2'b00, 16'hFFFF, rd, lat, busy, rc);
    step();
    check(ce_low_cnt == ce0, "R6", "no chip select cycles", 32'(ce_low_cnt), 32'(ce0));
    do_req(1'b0, 20'h00009, 2'b11, 16'h0, rd, lat, busy, rc);
    check(rd == expv[9], "R6", "zero-select write left memory", 32'(rd), 32'(expv[9]));
  endtask

  task automatic t_turnaround();
    logic [15:0] rd; int lat, rc; bit busy;
    do_req(1'b1, 20'h00003, 2'b11, 16'h5AA5, rd, lat, busy, rc);
    expv[3] = 16'h5AA5;
    do_req(1'b0, 20'h00003, 2'b11, 16'h0, rd, lat, busy, rc);
    check(rd == expv[3], "R7", "read right after write", 32'(rd), 32'(expv[3]));
    check(min_gap >= 2, "R7", "drive-to-read dead cycle", 32'(min_gap), 32'd2);
    check(fight_cnt == 0, "R7", "no bus fight", 32'(fight_cnt), 32'd0);
  endtask

  task automatic t_setup_hold();
    check(wr_seen > 0 && setup_err == 0, "R3", "strobe setup", 32'(setup_err), 32'd0);
    check(hold_err == 0, "R3", "strobe hold", 32'(hold_err), 32'd0);
  endtask

  bit done = 1'b0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_full_word();
    t_byte_write();
    t_lane_read();
    t_zero_select();
    t_turnaround();
    t_setup_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule